// File: doc/BRIEF.md
# Lowest-Priority Interrupt Target Selector

This block hands interrupt requests to one core out of a fixed pool of cores. A request carries a 4-bit unsigned priority, where a larger value is more urgent, and an 8-bit vector. Accepted requests wait in a small circular queue. Each core drives three things into the block: its current running priority, a mask bit and an acknowledge pulse. The block drives a pending line back to each core.

On every clock cycle the request at the head of the queue is offered to the pool. A core qualifies when three things hold: it is unmasked, its pending line is low, and its running priority is strictly below the request's priority. Among the qualifying cores, the one running at the lowest priority wins. If several share that lowest priority, the lowest core index wins. The winner's pending line rises and the delivered vector, priority and core index appear for one cycle. If no core qualifies, the head request moves to the tail of the queue, so the delivery path never stalls on it.

A source offers a request with `req_valid` and sees it accepted when `req_ready` is high. While the queue is full, `req_ready` is low and nothing is taken in.

Top module: `irq_lowpri_router`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `irq_pend` is all zero, `dlv_valid` and `fifo_nonempty` are 0, and `req_ready` is 1.
- R2: A core qualifies for the head request only if three conditions hold: its `core_mask` bit is 0, its `irq_pend` bit is 0, and its 4-bit running priority (bits [4i+3:4i] of `core_prio`) is strictly below the request priority. Priorities are compared as unsigned values.
- R3: Among the qualifying cores, the core with the numerically lowest running priority is chosen.
- R4: When several qualifying cores share the lowest running priority, the one with the lowest index is chosen.
- R5: A delivery decided at a clock edge makes `dlv_valid` high for exactly the following cycle. In that cycle `dlv_core` carries the chosen core as a binary index, and `dlv_vec` and `dlv_prio` carry the request's vector and priority. The chosen core's `irq_pend` bit rises at the same edge. At most one pending bit rises per edge.
- R6: An `irq_pend` bit stays high until that core's `core_ack` bit is high at a clock edge. An acknowledge to a core whose bit is low has no effect.
- R7: When no core qualifies, the head request is removed and written to the tail, and nothing is delivered. A new request accepted at the same edge is placed behind it.
- R8: `fifo_nonempty` is 1 exactly when the queue holds at least one request.
- R9: `req_ready` is 0 exactly when the queue holds DEPTH requests. A request offered while `req_ready` is 0 is not stored and is never delivered.
- R10: Whenever the queue is non-empty, the head request is resolved at every clock edge, either delivered or requeued. An empty queue produces no delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request offered |
| req_prio | input | PRIO_W | Priority of the offered request |
| req_vec | input | VEC_W | Vector of the offered request |
| req_ready | output | 1 | Queue can accept a request |
| core_prio | input | NUM_CORES*PRIO_W | Running priority of each core, core i in bits [PRIO_W*i +: PRIO_W] |
| core_mask | input | NUM_CORES | Per-core delivery mask, 1 blocks delivery |
| core_ack | input | NUM_CORES | Per-core acknowledge pulse |
| irq_pend | output | NUM_CORES | Per-core interrupt pending line |
| fifo_nonempty | output | 1 | Queue holds at least one request |
| dlv_valid | output | 1 | One-cycle delivery strobe |
| dlv_core | output | $clog2(NUM_CORES) | Index of the receiving core |
| dlv_vec | output | VEC_W | Vector of the delivered request |
| dlv_prio | output | PRIO_W | Priority of the delivered request |

## Verification
The bench builds the block with eight cores, 4-bit priorities, 8-bit vectors and a queue depth of four. With eight cores, the comparison tree has three full levels, so tie-breaks are exercised across both subtrees. A depth of four lets the directed part fill the queue in a few cycles. That reaches backpressure, a request offered while full, and a full queue that rotates through requeues. Random core priorities and masks then mix deliveries, requeues and acknowledges against a queue model kept in the bench.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // A core may take the head request when it is open, idle and below it.
  function automatic logic core_eligible(input logic masked,
                                         input logic busy,
                                         input logic below_req);
    return !masked && !busy && below_req;
  endfunction

  // Tree node rule: the left (lower index) child wins ties.
  function automatic logic keep_left(input logic left_ok,
                                     input logic right_ok,
                                     input logic left_le_right);
    return left_ok && (!right_ok || left_le_right);
  endfunction

endpackage

// File: rtl/irq_req_fifo.sv
module irq_req_fifo #(
  parameter int DEPTH  = 4,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rq_en,
  input  logic [PRIO_W-1:0] rq_prio,
  input  logic [VEC_W-1:0]  rq_vec,
  input  logic              new_en,
  input  logic [PRIO_W-1:0] new_prio,
  input  logic [VEC_W-1:0]  new_vec,
  input  logic              pop_en,
  output logic              head_valid,
  output logic [PRIO_W-1:0] head_prio,
  output logic [VEC_W-1:0]  head_vec,
  output logic              full,
  output logic [CNT_W-1:0]  count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] mem_p [DEPTH];
  logic [VEC_W-1:0]  mem_v [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr, wr_new_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // a requeued entry takes the first free slot, a new one the next
  assign wr_new_ptr = rq_en ? bump(wr_ptr) : wr_ptr;

  always_ff @(posedge clk) begin
    if (rq_en) begin
      mem_p[wr_ptr] <= rq_prio;
      mem_v[wr_ptr] <= rq_vec;
    end
    if (new_en) begin
      mem_p[wr_new_ptr] <= new_prio;
      mem_v[wr_new_ptr] <= new_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop_en) rd_ptr <= bump(rd_ptr);
      if (rq_en && new_en)      wr_ptr <= bump(bump(wr_ptr));
      else if (rq_en || new_en) wr_ptr <= bump(wr_ptr);
      count <= count - CNT_W'(pop_en) + CNT_W'(rq_en) + CNT_W'(new_en);
    end
  end

  assign head_valid = (count != '0);
  assign full       = (count == CNT_W'(DEPTH));
  assign head_prio  = mem_p[rd_ptr];
  assign head_vec   = mem_v[rd_ptr];

endmodule

// File: rtl/irq_lowpri_pick.sv
module irq_lowpri_pick
  import irq_router_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int PRIO_W    = 4,
  parameter int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [PRIO_W-1:0]           req_prio,
  input  logic [NUM_CORES*PRIO_W-1:0] core_prio,
  input  logic [NUM_CORES-1:0]        core_mask,
  input  logic [NUM_CORES-1:0]        core_busy,
  output logic                        found,
  output logic [IDX_W-1:0]            sel_idx
);
  localparam int LEAVES = 1 << IDX_W;
  localparam int NODES  = 2 * LEAVES - 1;

  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [IDX_W-1:0]  ni [NODES];

  // leaves sit left to right in core order
  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < NUM_CORES) begin : g_real
      logic [PRIO_W-1:0] cp;
      assign cp               = core_prio[j*PRIO_W +: PRIO_W];
      assign nv[LEAVES-1+j]   = core_eligible(core_mask[j], core_busy[j], cp < req_prio);
      assign np[LEAVES-1+j]   = cp;
      assign ni[LEAVES-1+j]   = IDX_W'(j);
    end else begin : g_pad
      assign nv[LEAVES-1+j]   = 1'b0;
      assign np[LEAVES-1+j]   = '0;
      assign ni[LEAVES-1+j]   = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic take_l;
    assign take_l = keep_left(nv[2*k+1], nv[2*k+2], np[2*k+1] <= np[2*k+2]);
    assign nv[k]  = nv[2*k+1] | nv[2*k+2];
    assign np[k]  = take_l ? np[2*k+1] : np[2*k+2];
    assign ni[k]  = take_l ? ni[2*k+1] : ni[2*k+2];
  end

  assign found   = nv[0];
  assign sel_idx = ni[0];

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_CORES = 8,
  parameter int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [IDX_W-1:0]     set_idx,
  input  logic [NUM_CORES-1:0] core_ack,
  output logic [NUM_CORES-1:0] pend
);
  logic [NUM_CORES-1:0] set_mask;

  assign set_mask = set_en ? (NUM_CORES'(1) << set_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~core_ack) | set_mask;
  end

endmodule

// File: rtl/irq_lowpri_router.sv
module irq_lowpri_router #(
  parameter int NUM_CORES = 8,
  parameter int PRIO_W    = 4,
  parameter int VEC_W     = 8,
  parameter int DEPTH     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [PRIO_W-1:0]             req_prio,
  input  logic [VEC_W-1:0]              req_vec,
  output logic                          req_ready,
  input  logic [NUM_CORES*PRIO_W-1:0]   core_prio,
  input  logic [NUM_CORES-1:0]          core_mask,
  input  logic [NUM_CORES-1:0]          core_ack,
  output logic [NUM_CORES-1:0]          irq_pend,
  output logic                          fifo_nonempty,
  output logic                          dlv_valid,
  output logic [$clog2(NUM_CORES)-1:0]  dlv_core,
  output logic [VEC_W-1:0]              dlv_vec,
  output logic [PRIO_W-1:0]             dlv_prio
);
  localparam int IDX_W = $clog2(NUM_CORES);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // named internal events, also watched by the checker
  logic              head_valid;
  logic [PRIO_W-1:0] head_prio;
  logic [VEC_W-1:0]  head_vec;
  logic              fifo_full;
  logic [CNT_W-1:0]  fifo_count;
  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic              deliver_now;
  logic              requeue_now;
  logic              accept_now;

  assign accept_now  = req_valid && !fifo_full;
  assign deliver_now = head_valid && pick_found;
  assign requeue_now = head_valid && !pick_found;

  irq_req_fifo #(
    .DEPTH (DEPTH), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .CNT_W(CNT_W)
  ) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .rq_en     (requeue_now),
    .rq_prio   (head_prio),
    .rq_vec    (head_vec),
    .new_en    (accept_now),
    .new_prio  (req_prio),
    .new_vec   (req_vec),
    .pop_en    (head_valid),
    .head_valid(head_valid),
    .head_prio (head_prio),
    .head_vec  (head_vec),
    .full      (fifo_full),
    .count     (fifo_count)
  );

  irq_lowpri_pick #(
    .NUM_CORES(NUM_CORES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) i_pick (
    .req_prio (head_prio),
    .core_prio(core_prio),
    .core_mask(core_mask),
    .core_busy(irq_pend),
    .found    (pick_found),
    .sel_idx  (pick_idx)
  );

  irq_pend_bank #(
    .NUM_CORES(NUM_CORES), .IDX_W(IDX_W)
  ) i_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (deliver_now),
    .set_idx (pick_idx),
    .core_ack(core_ack),
    .pend    (irq_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_valid <= 1'b0;
      dlv_core  <= '0;
      dlv_vec   <= '0;
      dlv_prio  <= '0;
    end else begin
      dlv_valid <= deliver_now;
      if (deliver_now) begin
        dlv_core <= pick_idx;
        dlv_vec  <= head_vec;
        dlv_prio <= head_prio;
      end
    end
  end

  assign req_ready     = !fifo_full;
  assign fifo_nonempty = head_valid;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CORES = 8,
  parameter int PRIO_W    = 4,
  parameter int DEPTH     = 4,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic [NUM_CORES*PRIO_W-1:0] core_prio,
  input logic [NUM_CORES-1:0]        core_mask,
  input logic [NUM_CORES-1:0]        core_ack,
  input logic [NUM_CORES-1:0]        irq_pend,
  input logic                        fifo_nonempty,
  input logic                        dlv_valid,
  input logic [IDX_W-1:0]            dlv_core,
  input logic [PRIO_W-1:0]           dlv_prio,
  input logic [CNT_W-1:0]            fifo_count,
  input logic                        deliver_now,
  input logic                        requeue_now
);
  logic [NUM_CORES*PRIO_W-1:0] prev_prio;
  logic [NUM_CORES-1:0]        prev_mask;

  always_ff @(posedge clk) begin
    prev_prio <= core_prio;
    prev_mask <= core_mask;
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  // R9
  accept_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !deliver_now) |=> fifo_count == $past(fifo_count) + CNT_W'(1));

  // R5
  dlv_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> irq_pend[dlv_core]);

  // R2
  dlv_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (!prev_mask[dlv_core] && prev_prio[dlv_core*PRIO_W +: PRIO_W] < dlv_prio));

  // R5
  one_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pend & ~$past(irq_pend)));

  // R7
  requeue_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    requeue_now |=> !dlv_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_nonempty |=> !dlv_valid);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_pend[i]) |-> $past(core_ack[i]));
  end

endmodule

bind irq_lowpri_router irq_router_chk #(
  .NUM_CORES(NUM_CORES), .PRIO_W(PRIO_W), .DEPTH(DEPTH),
  .IDX_W($clog2(NUM_CORES)), .CNT_W($clog2(DEPTH + 1))
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .core_prio    (core_prio),
  .core_mask    (core_mask),
  .core_ack     (core_ack),
  .irq_pend     (irq_pend),
  .fifo_nonempty(fifo_nonempty),
  .dlv_valid    (dlv_valid),
  .dlv_core     (dlv_core),
  .dlv_prio     (dlv_prio),
  .fifo_count   (fifo_count),
  .deliver_now  (deliver_now),
  .requeue_now  (requeue_now)
);

// File: tb/test_irq_lowpri_router.sv
`timescale 1ns/1ps
module test_irq_lowpri_router;
  localparam int NC = 8, PW = 4, VW = 8, DEPTH = 4, IW = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [PW-1:0]     req_prio;
  logic [VW-1:0]     req_vec;
  logic              req_ready;
  logic [NC*PW-1:0]  core_prio;
  logic [NC-1:0]     core_mask, core_ack, irq_pend;
  logic              fifo_nonempty, dlv_valid;
  logic [IW-1:0]     dlv_core;
  logic [VW-1:0]     dlv_vec;
  logic [PW-1:0]     dlv_prio;

  irq_lowpri_router #(.NUM_CORES(NC), .PRIO_W(PW), .VEC_W(VW), .DEPTH(DEPTH)) i_irq_lowpri_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio), .req_vec(req_vec),
    .req_ready(req_ready), .core_prio(core_prio), .core_mask(core_mask), .core_ack(core_ack),
    .irq_pend(irq_pend), .fifo_nonempty(fifo_nonempty), .dlv_valid(dlv_valid),
    .dlv_core(dlv_core), .dlv_vec(dlv_vec), .dlv_prio(dlv_prio));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model of the queue and the pending lines
  int      mq_p[$];
  int      mq_v[$];
  bit [NC-1:0] m_pend = '0;
  bit      m_dv = 1'b0;
  int      m_core = 0, m_vec = 0, m_prio = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // linear scan: strictly lower priority replaces, so the first index keeps ties
  function automatic int best_core(int rp, bit [NC-1:0] pend, bit [NC-1:0] mask, bit [NC*PW-1:0] cp);
    int best = -1;
    int bp = 0;
    for (int i = 0; i < NC; i++) begin
      int p = int'(cp[i*PW +: PW]);
      if (!mask[i] && !pend[i] && p < rp && (best < 0 || p < bp)) begin
        best = i;
        bp = p;
      end
    end
    return best;
  endfunction

  function automatic bit [NC*PW-1:0] all_prio(int v);
    bit [NC*PW-1:0] r;
    for (int i = 0; i < NC; i++) r[i*PW +: PW] = v[PW-1:0];
    return r;
  endfunction

  task automatic model_step();
    bit [NC-1:0] np;
    bit acc;
    int b;
    acc  = req_valid && (mq_p.size() < DEPTH);
    np   = m_pend & ~core_ack;
    m_dv = 1'b0;
    if (mq_p.size() > 0) begin
      int hp = mq_p.pop_front();
      int hv = mq_v.pop_front();
      b = best_core(hp, m_pend, core_mask, core_prio);
      if (b >= 0) begin
        m_dv = 1'b1; m_core = b; m_vec = hv; m_prio = hp;
        np[b] = 1'b1;
      end else begin
        mq_p.push_back(hp);
        mq_v.push_back(hv);
      end
    end
    if (acc) begin
      mq_p.push_back(int'(req_prio));
      mq_v.push_back(int'(req_vec));
    end
    m_pend = np;
  endtask

  task automatic compare();
    chk(irq_pend == m_pend, "R5 R6 irq_pend", int'(irq_pend), int'(m_pend));
    chk(dlv_valid == m_dv, "R7 R10 dlv_valid", int'(dlv_valid), int'(m_dv));
    if (m_dv) begin
      chk(int'(dlv_core) == m_core, "R2 R3 R4 dlv_core", int'(dlv_core), m_core);
      chk(int'(dlv_vec) == m_vec, "R5 dlv_vec", int'(dlv_vec), m_vec);
      chk(int'(dlv_prio) == m_prio, "R5 dlv_prio", int'(dlv_prio), m_prio);
    end
    chk(fifo_nonempty == (mq_p.size() > 0), "R8 fifo_nonempty", int'(fifo_nonempty), int'(mq_p.size() > 0));
    chk(req_ready == (mq_p.size() < DEPTH), "R9 req_ready", int'(req_ready), int'(mq_p.size() < DEPTH));
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic apply(bit v, int p, int vec, bit [NC-1:0] mask, bit [NC*PW-1:0] cp, bit [NC-1:0] ack);
    req_valid = v;
    req_prio  = p[PW-1:0];
    req_vec   = vec[VW-1:0];
    core_mask = mask;
    core_prio = cp;
    core_ack  = ack;
    model_step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int dcount;
    bit [NC*PW-1:0] cp;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    req_valid = 0; req_prio = '0; req_vec = '0;
    core_mask = '0; core_prio = '0; core_ack = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(irq_pend == '0, "R1 irq_pend", int'(irq_pend), 0);
    chk(dlv_valid == 1'b0, "R1 dlv_valid", int'(dlv_valid), 0);
    chk(fifo_nonempty == 1'b0, "R1 fifo_nonempty", int'(fifo_nonempty), 0);
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    rst_n = 1'b1;
    apply(0, 0, 0, '0, all_prio(2), '0);

    // R4: all cores at priority 2, request 9 goes to core 0
    tick(); apply(1, 9, 8'h11, '0, all_prio(2), '0);
    tick(); apply(0, 0, 0, '0, all_prio(2), '0);
    tick();
    chk(dlv_valid && dlv_core == 0, "R4 tie to core 0", int'(dlv_core), 0);
    apply(0, 0, 0, '0, all_prio(2), 8'h01);
    tick();
    chk(irq_pend == '0, "R6 ack clears", int'(irq_pend), 0);

    // R3: core 5 runs lowest
    cp = all_prio(6); cp[5*PW +: PW] = 4'd1;
    apply(1, 7, 8'h5A, '0, cp, '0);
    tick(); apply(0, 0, 0, '0, cp, '0);
    tick();
    chk(dlv_valid && dlv_core == 5, "R3 lowest core", int'(dlv_core), 5);
    apply(0, 0, 0, '0, cp, 8'h02);
    tick();
    chk(irq_pend[5] == 1'b1, "R6 held without own ack", int'(irq_pend[5]), 1);
    apply(0, 0, 0, '0, cp, 8'h20);

    // R2/R7/R9: priorities equal to the request, nobody qualifies; fill past full
    for (int k = 0; k < 6; k++) begin
      tick(); apply(1, 7, 8'h30 + k, '0, all_prio(7), '0);
    end
    tick();
    chk(req_ready == 1'b0, "R9 full", int'(req_ready), 0);
    chk(dlv_valid == 1'b0, "R7 no delivery", int'(dlv_valid), 0);
    apply(1, 7, 8'h99, '0, all_prio(7), '0);
    // open the pool: exactly DEPTH deliveries on consecutive cycles
    dcount = 0;
    tick(); apply(0, 0, 0, '0, all_prio(0), '0);
    for (int k = 0; k < 6; k++) begin
      tick();
      if (dlv_valid) dcount++;
      apply(0, 0, 0, '0, all_prio(0), '0);
    end
    chk(dcount == DEPTH, "R9 R10 drained count", dcount, DEPTH);
    tick(); apply(0, 0, 0, '0, all_prio(0), '1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit [NC-1:0] mk;
      tick();
      for (int i = 0; i < NC; i++) mk[i] = ($urandom_range(0, 3) == 0);
      for (int i = 0; i < NC; i++) cp[i*PW +: PW] = PW'($urandom_range(0, 15));
      apply($urandom_range(0, 1) == 1, int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
            mk, cp, NC'($urandom_range(0, 255) & $urandom_range(0, 255)));
    end
    tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule